// File: doc/BRIEF.md
# Dual-Set Character Bank Mapper

This block translates a picture-fetch address in the 8 KB pattern window (13 address bits) into a physical 1 KB character bank index. Software programs two independent sets of bank registers over a CPU write port. The sprite set holds eight registers and the background set holds four. A geometry register decides how large each mapped page is: 8, 4, 2 or 1 KB. When a register is written, its value is expanded at once into per-slot 1 KB bank numbers for every slot that its page covers. Later geometry changes do not reshape slots that were already written.

Each fetch reads the slot chosen by address bits 12:10 from one of the two slot tables. With tall (8x16) sprites, sprite fetches read the sprite table and background fetches read the background table. With 8x8 sprites, every fetch reads whichever table the CPU wrote most recently. This choice is a two-state machine. State `SEL_A` (sprite table last written) moves to `SEL_B` on transition `B_WRITE`, which is any write to a background register. State `SEL_B` moves back to `SEL_A` on transition `A_WRITE`, which is any write to a sprite register. A shared high-bits register supplies bank bits 9:8 for later register writes. The result is truncated to a parameterised, power-of-two bank count.

Top module: `pattern_bank_mapper`

## Requirements
- R1: A write to 0x5101 stores bits 1:0 as the geometry (0 = 8 KB, 1 = 4 KB, 2 = 2 KB, 3 = 1 KB pages). Bits 7:2 are ignored.
- R2: In geometry 3, a write of v to sprite register n (0x5120+n, n = 0..7) sets sprite slot n to bank v.
- R3: In geometries 2, 1 and 0 (page of 2^k KB with k = 1, 2, 3), sprite register r maps only when its low k bits are all ones. It then covers the slots whose index shares r's upper bits, and slot s receives v·2^k + (s mod 2^k). Registers 1/3/5/7 map 2 KB pages, registers 3/7 map 4 KB pages, and register 7 maps the full 8 KB.
- R4: A register write that maps no slot in the current geometry leaves every slot unchanged.
- R5: A write to background register j (0x5128+j, j = 0..3) maps identically into slots j' and j'+4 of the background table. It uses 1 KB pages in geometry 3, 2 KB pages (registers 1 and 3) in geometry 2, and a 4 KB page (register 3) in geometries 0 and 1.
- R6: A write to 0x5130 stores bits 1:0 as bank bits 9:8, which are ORed into every later sprite or background register value. Slots written earlier are not changed.
- R7: Any write to a sprite register selects state SEL_A and any write to a background register selects state SEL_B, whether or not the write mapped a slot.
- R8: With tall_sprites = 1, sprite fetches use the sprite table and background fetches use the background table.
- R9: With tall_sprites = 0, all fetches use the background table in state SEL_B and the sprite table in state SEL_A.
- R10: After reset every slot of both tables holds bank 0, the geometry is 0, the high bits are 0 and the state is SEL_A.
- R11: The output bank index is the expanded value truncated to log2(BANK_COUNT) bits. With the default BANK_COUNT = 2048, this is 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern fetch address |
| spr_fetch | input | 1 | Current fetch is for a sprite |
| tall_sprites | input | 1 | 8x16 sprite size in effect |
| bank_idx | output | BANK_W | Physical 1 KB bank index for the fetch (combinational) |

## Verification
The hardest situation to reach from the ports is a slot table whose slots were written under several different geometries. In that case, a write in the current geometry overwrites only part of an older, larger page, and a later geometry change must leave the rest alone. The random phase interleaves geometry, high-bit and register writes, including addresses that map nothing. It also reads every slot through both tables by toggling the sprite-size and fetch-type inputs. A bench model, written as page arithmetic, tracks both tables and the last-written state.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam logic [15:0] ADDR_GEOM   = 16'h5101;
    localparam logic [15:0] ADDR_HIGH   = 16'h5130;
    localparam logic [15:0] ADDR_A_BASE = 16'h5120;
    localparam logic [15:0] ADDR_B_BASE = 16'h5128;
    localparam int          HIGH_W      = 2;
    localparam int          VAL_W       = 8 + HIGH_W;
    localparam int          SLOTS       = 8;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_state_e;
endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
    import pbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [1:0]        geom,
    output logic              wr_a,
    output logic              wr_b,
    output logic [2:0]        reg_idx_a,
    output logic [2:0]        reg_idx_b,
    output logic [VAL_W-1:0]  reg_val
);
    logic [HIGH_W-1:0] high_q;
    logic              wr_geom;
    logic              wr_high;

    always_comb begin
        wr_geom   = cpu_wr && (cpu_addr == ADDR_GEOM);
        wr_high   = cpu_wr && (cpu_addr == ADDR_HIGH);
        wr_a      = cpu_wr && (cpu_addr[15:3] == ADDR_A_BASE[15:3]);
        wr_b      = cpu_wr && (cpu_addr[15:2] == ADDR_B_BASE[15:2]);
        reg_idx_a = cpu_addr[2:0];
        reg_idx_b = {1'b0, cpu_addr[1:0]};
        reg_val   = {high_q, cpu_wdata};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geom   <= 2'd0;
            high_q <= '0;
        end else begin
            if (wr_geom) geom   <= cpu_wdata[1:0];
            if (wr_high) high_q <= cpu_wdata[HIGH_W-1:0];
        end
    end

    // R1: geometry changes only through its own register
    p_geom_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == ADDR_GEOM) |=> $stable(geom));
    // R6: high bits change only through their own register
    p_high_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == ADDR_HIGH) |=> $stable(high_q));
endmodule

// File: rtl/pbm_slot_table.sv
module pbm_slot_table
    import pbm_pkg::*;
#(
    parameter bit IS_BG  = 1'b0,
    parameter int BANK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        reg_idx,
    input  logic [VAL_W-1:0]  reg_val,
    input  logic [1:0]        geom,
    input  logic [2:0]        slot_sel,
    output logic [BANK_W-1:0] slot_bank
);
    localparam int FULL_W = VAL_W + 3;

    logic [SLOTS-1:0][BANK_W-1:0] slots;
    logic [SLOTS-1:0][BANK_W-1:0] nxt;
    logic [SLOTS-1:0]             hit;
    logic [1:0]                   k;
    logic [2:0]                   low_mask;
    logic                         reg_maps;

    // page exponent: background pages never exceed one 4 KB half
    always_comb begin
        k = 2'd3 - geom;
        if (IS_BG && k == 2'd3) k = 2'd2;
        low_mask = (3'b001 << k) - 3'b001;
        reg_maps = (reg_idx & low_mask) == low_mask;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [2:0] LS = IS_BG ? 3'(s % 4) : 3'(s);
        logic [FULL_W-1:0] full;
        assign full   = (FULL_W'(reg_val) << k) | FULL_W'(LS & low_mask);
        assign hit[s] = wr && reg_maps && ((reg_idx & ~low_mask) == (LS & ~low_mask));
        assign nxt[s] = BANK_W'(full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit[i]) slots[i] <= nxt[i];
            end
        end
    end

    assign slot_bank = slots[slot_sel];

    // R4: slots only move on a register write to this table
    p_slots_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(slots));
    // R5: a background table keeps both halves identical
    if (IS_BG) begin : g_bg_chk
        p_halves_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            slots[SLOTS/2-1:0] == slots[SLOTS-1:SLOTS/2]);
    end
endmodule

// File: rtl/pbm_sel_fsm.sv
module pbm_sel_fsm
    import pbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_a,
    input  logic wr_b,
    input  logic spr_fetch,
    input  logic tall_sprites,
    output logic use_bg
);
    sel_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEL_A: if (wr_b) state_nxt = SEL_B;   // B_WRITE
            SEL_B: if (wr_a) state_nxt = SEL_A;   // A_WRITE
            default: state_nxt = SEL_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEL_A;
        else        state <= state_nxt;
    end

    always_comb begin
        if (tall_sprites) use_bg = !spr_fetch;
        else              use_bg = (state == SEL_B);
    end

    // R7: last-written set follows the write strobes
    p_a_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> state == SEL_A);
    p_b_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> state == SEL_B);
    // R8: tall sprites never read the background table for sprite fetches
    p_tall_spr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tall_sprites && spr_fetch) |-> !use_bg);
endmodule

// File: rtl/pattern_bank_mapper.sv
module pattern_bank_mapper
    import pbm_pkg::*;
#(
    parameter int BANK_COUNT = 2048,
    localparam int BANK_W    = $clog2(BANK_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic [12:0]       ppu_addr,
    input  logic              spr_fetch,
    input  logic              tall_sprites,
    output logic [BANK_W-1:0] bank_idx
);
    logic [1:0]        geom;
    logic              wr_a, wr_b, use_bg;
    logic [2:0]        reg_idx_a, reg_idx_b;
    logic [VAL_W-1:0]  reg_val;
    logic [BANK_W-1:0] bank_a, bank_b;
    logic [2:0]        slot_sel;

    assign slot_sel = ppu_addr[12:10];

    pbm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .geom(geom), .wr_a(wr_a), .wr_b(wr_b),
        .reg_idx_a(reg_idx_a), .reg_idx_b(reg_idx_b), .reg_val(reg_val)
    );

    pbm_slot_table #(.IS_BG(1'b0), .BANK_W(BANK_W)) u_tab_a (
        .clk(clk), .rst_n(rst_n), .wr(wr_a), .reg_idx(reg_idx_a),
        .reg_val(reg_val), .geom(geom), .slot_sel(slot_sel), .slot_bank(bank_a)
    );

    pbm_slot_table #(.IS_BG(1'b1), .BANK_W(BANK_W)) u_tab_b (
        .clk(clk), .rst_n(rst_n), .wr(wr_b), .reg_idx(reg_idx_b),
        .reg_val(reg_val), .geom(geom), .slot_sel(slot_sel), .slot_bank(bank_b)
    );

    pbm_sel_fsm u_sel (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b),
        .spr_fetch(spr_fetch), .tall_sprites(tall_sprites), .use_bg(use_bg)
    );

    assign bank_idx = use_bg ? bank_b : bank_a;

    // R9: 8x8 mode reads one table for both fetch kinds
    p_short_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tall_sprites && $stable(tall_sprites) && !wr_a && !wr_b
         && $stable(ppu_addr)) |=> (!tall_sprites && $stable(ppu_addr)) |-> $stable(bank_idx));
endmodule

// File: tb/pattern_bank_mapper_tb.sv
module pattern_bank_mapper_tb;
    localparam int BANK_COUNT = 2048;
    localparam int BANK_W     = $clog2(BANK_COUNT);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic [12:0]       ppu_addr = '0;
    logic              spr_fetch = 1'b0;
    logic              tall_sprites = 1'b0;
    logic [BANK_W-1:0] bank_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int ref_a [8];
    int ref_b [8];
    int m_geom, m_high;
    bit m_blast;

    always #4 clk = ~clk;

    pattern_bank_mapper #(.BANK_COUNT(BANK_COUNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .spr_fetch(spr_fetch),
        .tall_sprites(tall_sprites), .bank_idx(bank_idx)
    );

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin ref_a[i] = 0; ref_b[i] = 0; end
        m_geom = 0; m_high = 0; m_blast = 1'b0;
    endfunction

    function automatic void model_write(int addr, int data);
        int pg, first, v;
        v = (m_high << 8) | data;
        if (addr == 'h5101) m_geom = data & 3;
        else if (addr == 'h5130) m_high = data & 3;
        else if (addr >= 'h5120 && addr <= 'h5127) begin
            m_blast = 1'b0;
            pg = 8 >> m_geom;
            if (((addr - 'h5120 + 1) % pg) == 0) begin
                first = addr - 'h5120 + 1 - pg;
                for (int i = 0; i < pg; i++) ref_a[first + i] = (v * pg + i) % BANK_COUNT;
            end
        end else if (addr >= 'h5128 && addr <= 'h512B) begin
            m_blast = 1'b1;
            pg = (m_geom == 3) ? 1 : (m_geom == 2) ? 2 : 4;
            if (((addr - 'h5128 + 1) % pg) == 0) begin
                first = addr - 'h5128 + 1 - pg;
                for (int i = 0; i < pg; i++) begin
                    ref_b[first + i]     = (v * pg + i) % BANK_COUNT;
                    ref_b[first + i + 4] = (v * pg + i) % BANK_COUNT;
                end
            end
        end
    endfunction

    function automatic int expect_bank(int slot, bit spr, bit tall);
        bit bg;
        bg = tall ? !spr : m_blast;
        return bg ? ref_b[slot] : ref_a[slot];
    endfunction

    task automatic wr(int addr, int data);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'(addr); cpu_wdata = 8'(data);
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(addr, data);
    endtask

    task automatic chk(string tag, int slot, bit spr, bit tall);
        int exp_v;
        ppu_addr = {3'(slot), 10'(($urandom % 1024))};
        spr_fetch = spr; tall_sprites = tall;
        #1;
        exp_v = expect_bank(slot, spr, tall);
        checks++;
        if (int'(bank_idx) != exp_v) begin
            errors++;
            $display("FAIL %s slot=%0d spr=%0d tall=%0d actual=%0h expected=%0h",
                     tag, slot, spr, tall, bank_idx, exp_v);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, both tables
        for (int s = 0; s < 8; s++) begin
            chk("R10", s, 1'b1, 1'b1);
            chk("R10", s, 1'b0, 1'b1);
        end
        // R1: upper data bits ignored, geometry 3
        wr('h5101, 'hFF);
        // R2: 1 KB sprite pages
        for (int n = 0; n < 8; n++) wr('h5120 + n, 'h10 + n);
        for (int s = 0; s < 8; s++) chk("R2", s, 1'b1, 1'b0);
        // R4: geometry 1, register 0 maps nothing
        wr('h5101, 'h01);
        wr('h5120, 'h55);
        for (int s = 0; s < 8; s++) chk("R4", s, 1'b0, 1'b0);
        // R3: geometry 2, register 5 covers slots 4,5
        wr('h5101, 'h02);
        wr('h5125, 'h21);
        for (int s = 0; s < 8; s++) chk("R3", s, 1'b1, 1'b0);
        // R3: geometry 1, register 3 covers low half
        wr('h5101, 'h01);
        wr('h5123, 'h09);
        for (int s = 0; s < 8; s++) chk("R3", s, 1'b0, 1'b0);
        // R5, R7: background writes in geometry 3, then geometry 2
        wr('h5101, 'h03);
        for (int j = 0; j < 4; j++) wr('h5128 + j, 'h30 + j);
        for (int s = 0; s < 8; s++) chk("R5", s, 1'b1, 1'b0);
        wr('h5101, 'h02);
        wr('h5128, 'h77);
        for (int s = 0; s < 8; s++) chk("R5", s, 1'b0, 1'b0);
        wr('h5129, 'h12);
        for (int s = 0; s < 8; s++) chk("R5", s, 1'b0, 1'b0);
        // R7: non-mapping sprite write still returns to sprite table
        wr('h5120, 'h66);
        for (int s = 0; s < 8; s++) chk("R7", s, 1'b0, 1'b0);
        // R6: high bits do not touch existing slots, then apply
        wr('h5130, 'h02);
        for (int s = 0; s < 8; s++) chk("R6", s, 1'b1, 1'b0);
        wr('h5101, 'h03);
        wr('h5122, 'h05);
        chk("R6", 2, 1'b1, 1'b0);
        // R11: truncation of a wide expanded value
        wr('h5130, 'h03);
        wr('h5101, 'h00);
        wr('h5127, 'hFF);
        for (int s = 0; s < 8; s++) chk("R11", s, 1'b1, 1'b0);
        // R8 and R9 across both fetch kinds
        for (int s = 0; s < 8; s++) begin
            chk("R8", s, 1'b1, 1'b1);
            chk("R8", s, 1'b0, 1'b1);
            chk("R9", s, 1'b0, 1'b0);
            chk("R9", s, 1'b1, 1'b0);
        end
        // random phase
        for (int it = 0; it < 600; it++) begin
            if ($urandom % 2 == 0) begin
                wr('h5100 + ($urandom % 'h34), $urandom % 256);
            end else begin
                bit tall;
                tall = 1'($urandom % 2);
                chk(tall ? "R8" : "R9", $urandom % 8, 1'($urandom % 2), tall);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule